// File: doc/BRIEF.md
# Sample-Hold and Converter Acquisition Sequencer

This block sits between the slave side of a low-rate sensor bus and an analog front end made of a sample-and-hold stage and an analog-to-digital converter. It idles until the bus logic strobes in an acquire command aimed at this sensor's address, or at the all-ones broadcast address. It then freezes the analog input by raising the hold control. One clock later it fires a single-cycle converter start. It then waits for end-of-conversion, captures the converted word, releases the hold and hands the word to the bus side with a one-cycle valid strobe.

The converter is clocked from the bus clock, so every step of an acquisition is counted in bus cycles. The same module serves every sensor on the bus. Only the triggering address changes, and it is set by the `SENSOR_ADDR` parameter. If the converter never reports completion, a bounded wait of `TIMEOUT_CYCLES` clocks ends the acquisition. In that case the block gives an error strobe instead of data.

The controller has six named states. ST_WAIT idles. ST_SETTLE raises the hold. ST_START pulses the start. ST_CONVERT waits for the converter. ST_DELIVER presents the result. ST_ABORT reports a timeout. The transitions are:
- ST_WAIT to ST_SETTLE on an acquire hit.
- ST_SETTLE to ST_START, and ST_START to ST_CONVERT, unconditionally.
- ST_CONVERT to ST_DELIVER on end-of-conversion.
- ST_CONVERT to ST_ABORT on expiry of the wait.
- ST_DELIVER and ST_ABORT back to ST_WAIT unconditionally.

Top module: `acq_sequencer`

## Requirements
- R1: While waiting, a strobed command with op 2'b00 (idle), 2'b01 (reset) or 2'b11 (spare), or an acquire to a foreign address, changes nothing. sh_hold, adc_start, rd_valid and rd_err stay low, and rd_data keeps its value.
- R2: A strobed command with op 2'b10 (acquire) and cmd_addr equal to SENSOR_ADDR, seen at a clock edge while waiting, raises sh_hold in the cycle that follows.
- R3: sh_hold stays high from its rise until end-of-conversion is taken or the wait expires.
- R4: The word on adc_data in the cycle in which adc_eoc is sampled high during conversion appears on rd_data in the next cycle. rd_data then holds that word until the next successful capture.
- R5: rd_valid is a single-cycle pulse in the cycle after end-of-conversion is taken. The block then returns to waiting and accepts the next acquire.
- R6: An acquire to the broadcast address (all ones, 5'h1F by default) starts an acquisition just as the own address does.
- R7: adc_start is a single-cycle pulse in the second cycle of sh_hold, one clock after the hold rose, with exactly one pulse per acquisition.
- R8: sh_hold is low in the cycle that carries rd_valid. This returns the sample-and-hold to tracking one clock after end-of-conversion is seen.
- R9: End-of-conversion is accepted during the TIMEOUT_CYCLES cycles that follow the start pulse, including the last of them. If none arrives, rd_err pulses for one cycle TIMEOUT_CYCLES+1 cycles after the start pulse, with sh_hold low, and rd_data is unchanged.
- R10: An acquire command that arrives while an acquisition is in progress is ignored. It causes no second start pulse and no second result.
- R11: During and right after reset, sh_hold, adc_start, rd_valid and rd_err are low and rd_data is zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock; also paces the converter |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_stb | input | 1 | Command present this cycle |
| cmd_addr | input | ADDR_W | Target sensor address of the command |
| cmd_op | input | 2 | Command code: 00 idle, 01 reset, 10 acquire, 11 spare |
| adc_eoc | input | 1 | Converter end-of-conversion flag |
| adc_data | input | DATA_W | Converter result, valid with adc_eoc |
| sh_hold | output | 1 | High: sample-and-hold holds; low: tracks |
| adc_start | output | 1 | One-cycle converter start pulse |
| rd_data | output | DATA_W | Last captured conversion word |
| rd_valid | output | 1 | One-cycle strobe: rd_data holds a new result |
| rd_err | output | 1 | One-cycle strobe: acquisition timed out |

## Verification
The assertions assume that the converter raises adc_eoc only while a conversion it was asked for is in flight, and never during the hold or start cycles. They also assume that each command is strobed for a single cycle. The bench's converter model keeps to this. It waits for the start pulse before it counts its conversion delay, and it never answers an acquisition that the bench means to time out. Commands are driven on falling edges for exactly one cycle. Extra acquire commands are sent only when the block is either idle or deep inside a conversion.

// File: rtl/acq_pkg.sv
package acq_pkg;

    typedef enum logic [2:0] {
        ST_WAIT    = 3'd0,
        ST_SETTLE  = 3'd1,
        ST_START   = 3'd2,
        ST_CONVERT = 3'd3,
        ST_DELIVER = 3'd4,
        ST_ABORT   = 3'd5
    } acq_state_t;

    localparam int          OP_W       = 2;
    localparam logic [1:0]  OP_IDLE    = 2'b00;
    localparam logic [1:0]  OP_RESET   = 2'b01;
    localparam logic [1:0]  OP_ACQUIRE = 2'b10;
    localparam logic [1:0]  OP_SPARE   = 2'b11;

endpackage

// File: rtl/acq_cmd_match.sv
module acq_cmd_match
    import acq_pkg::*;
#(
    parameter int ADDR_W      = 5,
    parameter int SENSOR_ADDR = 6,
    parameter bit BCAST_EN    = 1'b1
) (
    input  logic              cmd_stb,
    input  logic [ADDR_W-1:0] cmd_addr,
    input  logic [OP_W-1:0]   cmd_op,
    output logic              acq_hit
);
    localparam logic [ADDR_W-1:0] OWN_ADDR   = ADDR_W'(SENSOR_ADDR);
    localparam logic [ADDR_W-1:0] BCAST_ADDR = {ADDR_W{1'b1}};

    logic addr_ok;

    generate
        if (BCAST_EN) begin : g_bcast
            assign addr_ok = (cmd_addr == OWN_ADDR) || (cmd_addr == BCAST_ADDR);
        end else begin : g_own_only
            assign addr_ok = (cmd_addr == OWN_ADDR);
        end
    endgenerate

    // Idle, reset and spare codes never produce a hit.
    assign acq_hit = cmd_stb && addr_ok && (cmd_op == OP_ACQUIRE);

endmodule

// File: rtl/acq_conv_timer.sv
module acq_conv_timer #(
    parameter int LIMIT = 256
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic expired
);
    localparam int CNT_W = (LIMIT > 2) ? $clog2(LIMIT) : 1;
    localparam logic [CNT_W-1:0] LAST = CNT_W'(LIMIT - 1);

    logic [CNT_W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (!rst_n || !run) begin
            cnt <= '0;
        end else if (cnt != LAST) begin
            cnt <= cnt + 1'b1;
        end
    end

    assign expired = run && (cnt == LAST);

endmodule

// File: rtl/acq_result_reg.sv
module acq_result_reg #(
    parameter int DATA_W = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              capture,
    input  logic [DATA_W-1:0] din,
    output logic [DATA_W-1:0] dout
);
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dout <= '0;
        end else if (capture) begin
            dout <= din;
        end
    end

endmodule

// File: rtl/acq_sequencer.sv
module acq_sequencer
    import acq_pkg::*;
#(
    parameter int DATA_W         = 12,
    parameter int ADDR_W         = 5,
    parameter int SENSOR_ADDR    = 6,
    parameter bit BCAST_EN       = 1'b1,
    parameter int TIMEOUT_CYCLES = 256
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_stb,
    input  logic [ADDR_W-1:0] cmd_addr,
    input  logic [1:0]        cmd_op,
    input  logic              adc_eoc,
    input  logic [DATA_W-1:0] adc_data,
    output logic              sh_hold,
    output logic              adc_start,
    output logic [DATA_W-1:0] rd_data,
    output logic              rd_valid,
    output logic              rd_err
);
    acq_state_t state, state_nx;
    logic       acq_hit;
    logic       conv_run;
    logic       tmo_expire;
    logic       eoc_take;

    acq_cmd_match #(
        .ADDR_W      (ADDR_W),
        .SENSOR_ADDR (SENSOR_ADDR),
        .BCAST_EN    (BCAST_EN)
    ) u_match (
        .cmd_stb  (cmd_stb),
        .cmd_addr (cmd_addr),
        .cmd_op   (cmd_op),
        .acq_hit  (acq_hit)
    );

    assign conv_run = (state == ST_CONVERT);
    assign eoc_take = conv_run && adc_eoc;

    acq_conv_timer #(
        .LIMIT (TIMEOUT_CYCLES)
    ) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .run     (conv_run),
        .expired (tmo_expire)
    );

    acq_result_reg #(
        .DATA_W (DATA_W)
    ) u_result (
        .clk     (clk),
        .rst_n   (rst_n),
        .capture (eoc_take),
        .din     (adc_data),
        .dout    (rd_data)
    );

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_WAIT;
        end else begin
            state <= state_nx;
        end
    end

    // Transitions
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_WAIT:    if (acq_hit) state_nx = ST_SETTLE;
            ST_SETTLE:  state_nx = ST_START;
            ST_START:   state_nx = ST_CONVERT;
            ST_CONVERT: begin
                if (adc_eoc)         state_nx = ST_DELIVER;
                else if (tmo_expire) state_nx = ST_ABORT;
            end
            ST_DELIVER: state_nx = ST_WAIT;
            ST_ABORT:   state_nx = ST_WAIT;
            default:    state_nx = ST_WAIT;
        endcase
    end

    // Outputs
    always_comb begin
        sh_hold   = 1'b0;
        adc_start = 1'b0;
        rd_valid  = 1'b0;
        rd_err    = 1'b0;
        unique case (state)
            ST_WAIT:    ;
            ST_SETTLE:  sh_hold = 1'b1;
            ST_START: begin
                sh_hold   = 1'b1;
                adc_start = 1'b1;
            end
            ST_CONVERT: sh_hold = 1'b1;
            ST_DELIVER: rd_valid = 1'b1;
            ST_ABORT:   rd_err = 1'b1;
            default:    ;
        endcase
    end

endmodule

// File: rtl/acq_sequencer_checker.sv
module acq_sequencer_checker
    import acq_pkg::*;
#(
    parameter int DATA_W      = 12,
    parameter int ADDR_W      = 5,
    parameter int SENSOR_ADDR = 6
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cmd_stb,
    input logic [ADDR_W-1:0] cmd_addr,
    input logic [1:0]        cmd_op,
    input logic              adc_eoc,
    input logic [DATA_W-1:0] adc_data,
    input logic              sh_hold,
    input logic              adc_start,
    input logic [DATA_W-1:0] rd_data,
    input logic              rd_valid,
    input logic              rd_err,
    input acq_state_t        state,
    input logic              tmo_expire
);
    logic own_acq;
    assign own_acq = cmd_stb && (cmd_op == OP_ACQUIRE) && (cmd_addr == ADDR_W'(SENSOR_ADDR));

    // R1: a non-acquire command while idle leaves hold low
    assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (!sh_hold && cmd_stb && cmd_op != OP_ACQUIRE) |=> !sh_hold);

    // R2: own-address acquire while waiting raises hold
    assert_acq_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_WAIT && own_acq) |=> sh_hold);

    // R3: hold held during conversion unless eoc or expiry
    assert_hold_stable_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (sh_hold && !adc_eoc && !tmo_expire) |=> sh_hold);

    // R4: captured word matches converter data
    assert_capture_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_CONVERT && adc_eoc) |=> (rd_valid && rd_data == $past(adc_data)));

    // R5: valid and error never together, valid lasts one cycle
    assert_valid_pulse_R5: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |-> !rd_err);
    assert_valid_single_R5: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |=> !rd_valid);

    // R7: start one cycle, only under hold, after hold already high
    assert_start_under_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        adc_start |-> (sh_hold && $past(sh_hold)));
    assert_start_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
        adc_start |=> !adc_start);

    // R8: hold released together with the valid strobe
    assert_release_R8: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |-> !sh_hold);

    // R9: error only after a held conversion without eoc, data untouched
    assert_timeout_R9: assert property (@(posedge clk) disable iff (!rst_n)
        rd_err |-> (!sh_hold && $past(sh_hold) && !$past(adc_eoc) && $stable(rd_data)));

    // R10: no restart while converting
    assert_busy_ignore_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_CONVERT) |=> !adc_start);

endmodule

bind acq_sequencer acq_sequencer_checker #(
    .DATA_W      (DATA_W),
    .ADDR_W      (ADDR_W),
    .SENSOR_ADDR (SENSOR_ADDR)
) u_checker (
    .clk        (clk),
    .rst_n      (rst_n),
    .cmd_stb    (cmd_stb),
    .cmd_addr   (cmd_addr),
    .cmd_op     (cmd_op),
    .adc_eoc    (adc_eoc),
    .adc_data   (adc_data),
    .sh_hold    (sh_hold),
    .adc_start  (adc_start),
    .rd_data    (rd_data),
    .rd_valid   (rd_valid),
    .rd_err     (rd_err),
    .state      (state),
    .tmo_expire (tmo_expire)
);

// File: tb/acq_sequencer_bench.sv
module acq_sequencer_bench;
    localparam int DW   = 12;
    localparam int AW   = 5;
    localparam int ADDR = 6;
    localparam int TMO  = 256;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cmd_stb = 1'b0;
    logic [AW-1:0] cmd_addr = '0;
    logic [1:0]    cmd_op = 2'b00;
    logic          adc_eoc = 1'b0;
    logic [DW-1:0] adc_data = '0;
    logic          sh_hold, adc_start, rd_valid, rd_err;
    logic [DW-1:0] rd_data;

    acq_sequencer #(
        .DATA_W (DW), .ADDR_W (AW), .SENSOR_ADDR (ADDR),
        .BCAST_EN (1'b1), .TIMEOUT_CYCLES (TMO)
    ) u_acq_sequencer (
        .clk (clk), .rst_n (rst_n), .cmd_stb (cmd_stb), .cmd_addr (cmd_addr),
        .cmd_op (cmd_op), .adc_eoc (adc_eoc), .adc_data (adc_data),
        .sh_hold (sh_hold), .adc_start (adc_start), .rd_data (rd_data),
        .rd_valid (rd_valid), .rd_err (rd_err)
    );

    always #2 clk = ~clk;   // 250 MHz

    typedef struct { logic err; logic [DW-1:0] data; string req; } exp_t;
    exp_t exp_q[$];

    int n_checks = 0;
    int n_fail   = 0;
    int cyc      = 0;
    int n_start  = 0;
    int start_cyc = 0;
    int conv_delay = 4;
    logic [DW-1:0] conv_value = '0;
    bit  adc_mute = 1'b0;
    bit  finished = 1'b0;

    always @(posedge clk) cyc <= cyc + 1;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h (cycle %0d)", req, act, exp, cyc);
        end
    endtask

    task automatic send_cmd(input logic [AW-1:0] a, input logic [1:0] op);
        @(negedge clk);
        cmd_stb = 1'b1; cmd_addr = a; cmd_op = op;
        @(negedge clk);
        cmd_stb = 1'b0;
    endtask

    task automatic acquire(input logic [AW-1:0] a, input int dly, input logic [DW-1:0] v,
                           input bit mute, input string req);
        exp_t e;
        conv_delay = dly; conv_value = v; adc_mute = mute;
        e.err = mute; e.data = v; e.req = req;
        exp_q.push_back(e);
        send_cmd(a, 2'b10);
    endtask

    task automatic wait_idle();
        while (exp_q.size() != 0) @(negedge clk);
        repeat (3) @(negedge clk);
    endtask

    // Converter model: answers conv_delay cycles after the start pulse
    initial begin
        forever begin
            @(negedge clk);
            if (rst_n && adc_start && !adc_mute) begin
                for (int i = 0; i < conv_delay; i++) begin
                    @(negedge clk);
                    chk(sh_hold == 1'b1, "R3 hold during conversion", sh_hold, 1);
                end
                adc_data = conv_value;
                adc_eoc  = 1'b1;
                @(negedge clk);
                adc_eoc  = 1'b0;
                adc_data = ~conv_value;
            end
        end
    end

    // Monitor / scoreboard
    always @(negedge clk) begin
        if (rst_n) begin
            if (adc_start) begin
                n_start++;
                start_cyc = cyc;
            end
            if (rd_valid || rd_err) begin
                if (exp_q.size() == 0) begin
                    chk(1'b0, "R10 unexpected result", {rd_err, rd_valid}, 0);
                end else begin
                    exp_t e;
                    e = exp_q.pop_front();
                    chk(rd_err == e.err, {e.req, " error flag"}, rd_err, e.err);
                    chk(rd_valid == !e.err, {e.req, " R5 valid flag"}, rd_valid, !e.err);
                    chk(sh_hold == 1'b0, "R8 hold released at result", sh_hold, 0);
                    if (!e.err) begin
                        chk(rd_data == e.data, {e.req, " R4 data"}, rd_data, e.data);
                    end else begin
                        chk(cyc - start_cyc == TMO + 1, "R9 timeout distance",
                            cyc - start_cyc, TMO + 1);
                    end
                end
            end
        end
    end

    // Watchdog
    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual hung expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        int s0;
        logic [DW-1:0] last;

        repeat (3) @(negedge clk);
        // R11: reset values
        chk(sh_hold == 0 && adc_start == 0, "R11 hold/start in reset", {sh_hold, adc_start}, 0);
        chk(rd_valid == 0 && rd_err == 0, "R11 strobes in reset", {rd_valid, rd_err}, 0);
        chk(rd_data == 0, "R11 data in reset", rd_data, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(sh_hold == 0 && rd_data == 0, "R11 after reset", {sh_hold, rd_data}, 0);

        // R1: idle, reset, spare, foreign address
        s0 = n_start;
        send_cmd(AW'(ADDR), 2'b00);
        send_cmd(AW'(ADDR), 2'b01);
        send_cmd(AW'(ADDR), 2'b11);
        send_cmd(AW'(3), 2'b10);
        repeat (4) begin
            @(negedge clk);
            chk(sh_hold == 0 && rd_valid == 0 && rd_err == 0, "R1 quiet outputs",
                {sh_hold, rd_valid, rd_err}, 0);
        end
        chk(n_start == s0, "R1 no start pulse", n_start, s0);
        chk(rd_data == 0, "R1 data untouched", rd_data, 0);

        // R2/R7: exact hold and start timing
        begin
            exp_t e;
            conv_delay = 5; conv_value = 12'hA5C; adc_mute = 0;
            e.err = 0; e.data = 12'hA5C; e.req = "R2";
            exp_q.push_back(e);
            @(negedge clk);
            cmd_stb = 1; cmd_addr = AW'(ADDR); cmd_op = 2'b10;
            @(negedge clk);
            cmd_stb = 0;
            chk(sh_hold == 1, "R2 hold after command", sh_hold, 1);
            chk(adc_start == 0, "R7 no start in first hold cycle", adc_start, 0);
            @(negedge clk);
            chk(adc_start == 1 && sh_hold == 1, "R7 start in second hold cycle",
                {adc_start, sh_hold}, 3);
            @(negedge clk);
            chk(adc_start == 0, "R7 start one cycle", adc_start, 0);
            wait_idle();
        end

        // R4/R5: several delays and words, back to back
        acquire(AW'(ADDR), 1, 12'h000, 0, "R4 zero");
        wait_idle();
        acquire(AW'(ADDR), 3, 12'hFFF, 0, "R4 all ones");
        wait_idle();
        acquire(AW'(ADDR), 40, 12'h5A3, 0, "R5 long");
        wait_idle();

        // R6: broadcast
        acquire(5'h1F, 2, 12'h3C1, 0, "R6 broadcast");
        wait_idle();

        // R10: extra acquire during conversion
        s0 = n_start;
        acquire(AW'(ADDR), 30, 12'h777, 0, "R10 first");
        repeat (10) @(negedge clk);
        send_cmd(AW'(ADDR), 2'b10);
        wait_idle();
        repeat (5) @(negedge clk);
        chk(n_start == s0 + 1, "R10 single start", n_start, s0 + 1);

        // R9: eoc on the last allowed cycle still succeeds
        acquire(AW'(ADDR), TMO, 12'h9E2, 0, "R9 boundary");
        wait_idle();

        // R9: no eoc at all -> error, data kept
        last = rd_data;
        acquire(AW'(ADDR), 1, 12'h111, 1, "R9 timeout");
        wait_idle();
        chk(rd_data == last, "R9 data kept after timeout", rd_data, last);

        // R5: recovery after timeout
        acquire(AW'(ADDR), 2, 12'h2B4, 0, "R5 recovery");
        wait_idle();

        finished = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end

endmodule